// File: doc/BRIEF.md
# Multi-Queue Shared-Memory FIFO

This block keeps many first-in first-out queues in one shared storage array. Writes and reads each pass through a single data bus. A queue number presented with each strobe picks the queue. The write side and the read side are independent. They may address different queues or the same queue in the same clock cycle. Each queue owns a contiguous region of the array. Its write and read offsets wrap inside that region, and it keeps its own occupancy count.

Two flags follow the queue currently addressed: a full flag for the write side and an empty flag for the read side. Two vectors carry one almost-full bit and one almost-empty bit per queue, and each queue has its own thresholds. A mode pin is sampled while reset is held low, so the last value before reset is released is the one kept. With the pin low, the block starts in a fixed default layout and ignores configuration writes. With the pin high, every queue starts unconfigured. Queues are then defined one at a time through a small configuration port, and each new queue is placed directly after the previous one in the array.

Top module: `mq_fifo`

## Requirements
- R1: The mode pin value held during the last reset cycle is kept until the next reset. Low means default layout: queues 0 to DEF_Q-1 each hold RAM_DEPTH/DEF_Q words (64 with the default parameters), both thresholds are 4, and every other queue is unconfigured. High means every queue starts unconfigured.
- R2: An accepted write stores wr_data_i in the queue named by wr_q_i. Reads from the queue named by rd_q_i return that queue's words in the order they were written, unaffected by traffic to other queues.
- R3: An accepted read puts its word on rd_data_o, with rd_valid_o high, on the clock edge that follows the strobe cycle. rd_valid_o is low after any cycle with no accepted read.
- R4: full_o is high when the queue selected by wr_q_i holds as many words as its size. An unconfigured queue has size 0, so it always reads as full and empty.
- R5: empty_o is high when the queue selected by rd_q_i holds no words.
- R6: A write to a full queue is ignored. The queue's contents and count stay unchanged.
- R7: A read from an empty queue is ignored. rd_valid_o stays low and the pointers stay unchanged.
- R8: A write and a read accepted in the same cycle on the same queue leave its count unchanged. A write to an empty queue in the same cycle as a read of that queue is accepted, and the read is ignored.
- R9: afull_o[q] is high when queue q is configured and count + almost-full threshold >= size. aempty_o[q] is high when count <= almost-empty threshold.
- R10: In the mode selected by a high pin, a configuration write is accepted only under three conditions: the named queue is still unconfigured, the size is nonzero, and the size fits in the space left. An accepted write gives the queue the next free base address and clears its pointers. Any other configuration write, and every configuration write in default mode, is ignored.
- R11: The write and read offsets wrap at the end of a queue's region. Traffic that wraps never touches a neighbouring queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| prog_mode_i | input | 1 | Mode pin sampled during reset (1 = configurable, 0 = default layout) |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_q_i | input | QW | Queue being configured |
| cfg_size_i | input | CW | Queue size in words |
| cfg_af_i | input | CW | Almost-full threshold |
| cfg_ae_i | input | CW | Almost-empty threshold |
| wr_en_i | input | 1 | Write strobe |
| wr_q_i | input | QW | Write queue select |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_q_i | input | QW | Read queue select |
| rd_data_o | output | DATA_W | Read data, one cycle after the strobe |
| rd_valid_o | output | 1 | Read data valid |
| full_o | output | 1 | Selected write queue is full |
| empty_o | output | 1 | Selected read queue is empty |
| afull_o | output | MAX_Q | Almost-full bit per queue |
| aempty_o | output | MAX_Q | Almost-empty bit per queue |

## Verification
A wrong count or a wrong pointer shows up at the ports within a cycle or two. A flag changes state at the wrong fill level, or the read that follows returns a word from the wrong place in the queue or from a neighbouring region. A base address allocated wrongly shows up as corrupted data once two queues are filled side by side. A fault in the wrap logic stays hidden until a queue has cycled past the end of its region. For that reason the directed cases fill a queue completely, drain it, and then refill it across the boundary before checking the data.

// File: rtl/mq_fifo_pkg.sv
package mq_fifo_pkg;
    typedef enum logic [0:0] {
        MODE_DEFAULT = 1'b0,
        MODE_PROG    = 1'b1
    } mq_mode_e;
endpackage

// File: rtl/mq_ram.sv
module mq_ram #(
    parameter int DATA_W    = 16,
    parameter int RAM_DEPTH = 256,
    localparam int AW       = $clog2(RAM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              re_i,
    input  logic [AW-1:0]     raddr_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } rd_t;

    logic [DATA_W-1:0] mem [RAM_DEPTH];
    rd_t r_d, r_q;

    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = re_i;
        if (re_i) r_d.rdata = mem[raddr_i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdata_o  = r_q.rdata;
    assign rvalid_o = r_q.rvalid;

    AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        re_i |=> rvalid_o); // R3
    AST_RVALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !re_i |=> !rvalid_o); // R3
endmodule

// File: rtl/mq_layout.sv
module mq_layout
    import mq_fifo_pkg::*;
#(
    parameter int MAX_Q     = 32,
    parameter int RAM_DEPTH = 256,
    parameter int DEF_Q     = 4,
    parameter int DEF_AF    = 4,
    parameter int DEF_AE    = 4,
    localparam int AW       = $clog2(RAM_DEPTH),
    localparam int CW       = $clog2(RAM_DEPTH + 1),
    localparam int QW       = (MAX_Q > 1) ? $clog2(MAX_Q) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       prog_mode_i,
    input  logic                       cfg_we_i,
    input  logic [QW-1:0]              cfg_q_i,
    input  logic [CW-1:0]              cfg_size_i,
    input  logic [CW-1:0]              cfg_af_i,
    input  logic [CW-1:0]              cfg_ae_i,
    output logic [MAX_Q-1:0][AW-1:0]   base_o,
    output logic [MAX_Q-1:0][CW-1:0]   size_o,
    output logic [MAX_Q-1:0][CW-1:0]   af_o,
    output logic [MAX_Q-1:0][CW-1:0]   ae_o,
    output logic                       load_o,
    output logic [QW-1:0]              load_q_o
);
    localparam int DSZ = RAM_DEPTH / DEF_Q;

    typedef struct packed {
        mq_mode_e                   mode;
        logic [CW-1:0]              alloc;
        logic [MAX_Q-1:0][AW-1:0]   base;
        logic [MAX_Q-1:0][CW-1:0]   size;
        logic [MAX_Q-1:0][CW-1:0]   af;
        logic [MAX_Q-1:0][CW-1:0]   ae;
    } lay_t;

    lay_t s_d, s_q, s_rst;
    logic accept;

    always_comb begin
        s_rst      = '0;
        s_rst.mode = prog_mode_i ? MODE_PROG : MODE_DEFAULT;
        if (!prog_mode_i) begin
            for (int q = 0; q < MAX_Q; q++) begin
                if (q < DEF_Q) begin
                    s_rst.base[q] = AW'(q * DSZ);
                    s_rst.size[q] = CW'(DSZ);
                    s_rst.af[q]   = CW'(DEF_AF);
                    s_rst.ae[q]   = CW'(DEF_AE);
                end
            end
            s_rst.alloc = CW'(DEF_Q * DSZ);
        end
    end

    always_comb begin
        s_d    = s_q;
        accept = (s_q.mode == MODE_PROG) && cfg_we_i
              && (s_q.size[cfg_q_i] == '0) && (cfg_size_i != '0)
              && (({1'b0, s_q.alloc} + {1'b0, cfg_size_i}) <= (CW+1)'(RAM_DEPTH));
        if (accept) begin
            s_d.base[cfg_q_i] = s_q.alloc[AW-1:0];
            s_d.size[cfg_q_i] = cfg_size_i;
            s_d.af[cfg_q_i]   = cfg_af_i;
            s_d.ae[cfg_q_i]   = cfg_ae_i;
            s_d.alloc         = s_q.alloc + cfg_size_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= s_rst;
        else        s_q <= s_d;
    end

    assign base_o   = s_q.base;
    assign size_o   = s_q.size;
    assign af_o     = s_q.af;
    assign ae_o     = s_q.ae;
    assign load_o   = accept;
    assign load_q_o = cfg_q_i;

    AST_DEFAULT_NO_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MODE_DEFAULT) |-> !load_o); // R10
    AST_ALLOC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.alloc <= CW'(RAM_DEPTH)); // R10
    AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(s_q.mode)); // R1
endmodule

// File: rtl/mq_queues.sv
module mq_queues #(
    parameter int MAX_Q     = 32,
    parameter int RAM_DEPTH = 256,
    localparam int AW       = $clog2(RAM_DEPTH),
    localparam int CW       = $clog2(RAM_DEPTH + 1),
    localparam int QW       = (MAX_Q > 1) ? $clog2(MAX_Q) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [MAX_Q-1:0][AW-1:0]  base_i,
    input  logic [MAX_Q-1:0][CW-1:0]  size_i,
    input  logic [MAX_Q-1:0][CW-1:0]  af_i,
    input  logic [MAX_Q-1:0][CW-1:0]  ae_i,
    input  logic                      load_i,
    input  logic [QW-1:0]             load_q_i,
    input  logic                      wr_en_i,
    input  logic [QW-1:0]             wr_q_i,
    input  logic                      rd_en_i,
    input  logic [QW-1:0]             rd_q_i,
    output logic                      full_o,
    output logic                      empty_o,
    output logic [MAX_Q-1:0]          afull_o,
    output logic [MAX_Q-1:0]          aempty_o,
    output logic                      ram_we_o,
    output logic [AW-1:0]             ram_waddr_o,
    output logic                      ram_re_o,
    output logic [AW-1:0]             ram_raddr_o
);
    typedef struct packed {
        logic [MAX_Q-1:0][AW-1:0] wp;
        logic [MAX_Q-1:0][AW-1:0] rp;
        logic [MAX_Q-1:0][CW-1:0] cnt;
    } ptr_t;

    ptr_t s_d, s_q;
    logic wr_acc, rd_acc;
    logic [CW-1:0] wp_inc, rp_inc;

    always_comb begin
        full_o  = (s_q.cnt[wr_q_i] == size_i[wr_q_i]);
        empty_o = (s_q.cnt[rd_q_i] == '0);
        wr_acc  = wr_en_i && !full_o;
        rd_acc  = rd_en_i && !empty_o;
        wp_inc  = {1'b0, s_q.wp[wr_q_i]} + CW'(1);
        rp_inc  = {1'b0, s_q.rp[rd_q_i]} + CW'(1);

        s_d = s_q;
        if (wr_acc) begin
            s_d.wp[wr_q_i]  = (wp_inc == size_i[wr_q_i]) ? '0 : wp_inc[AW-1:0];
            s_d.cnt[wr_q_i] = s_q.cnt[wr_q_i] + CW'(1);
        end
        if (rd_acc) begin
            s_d.rp[rd_q_i]  = (rp_inc == size_i[rd_q_i]) ? '0 : rp_inc[AW-1:0];
            s_d.cnt[rd_q_i] = s_d.cnt[rd_q_i] - CW'(1);
        end
        if (load_i) begin
            s_d.wp[load_q_i]  = '0;
            s_d.rp[load_q_i]  = '0;
            s_d.cnt[load_q_i] = '0;
        end

        for (int q = 0; q < MAX_Q; q++) begin
            afull_o[q]  = (size_i[q] != '0)
                       && (({1'b0, s_q.cnt[q]} + {1'b0, af_i[q]}) >= {1'b0, size_i[q]});
            aempty_o[q] = (s_q.cnt[q] <= ae_i[q]);
        end

        ram_we_o    = wr_acc;
        ram_waddr_o = base_i[wr_q_i] + s_q.wp[wr_q_i];
        ram_re_o    = rd_acc;
        ram_raddr_o = base_i[rd_q_i] + s_q.rp[rd_q_i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt[wr_q_i] <= size_i[wr_q_i]); // R4
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && full_o && !load_i && !(rd_acc && rd_q_i == wr_q_i))
        |=> (s_q.cnt[$past(wr_q_i)] == $past(s_q.cnt[wr_q_i]))); // R6
    AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && empty_o && !load_i && !(wr_acc && rd_q_i == wr_q_i))
        |=> (s_q.rp[$past(rd_q_i)] == $past(s_q.rp[rd_q_i]))); // R7
    AST_SAME_Q_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && rd_acc && wr_q_i == rd_q_i && !load_i)
        |=> (s_q.cnt[$past(wr_q_i)] == $past(s_q.cnt[wr_q_i]))); // R8
    AST_WP_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i[wr_q_i] != '0) |-> ({1'b0, s_q.wp[wr_q_i]} < size_i[wr_q_i])); // R11
endmodule

// File: rtl/mq_fifo.sv
module mq_fifo #(
    parameter int DATA_W    = 16,
    parameter int MAX_Q     = 32,
    parameter int RAM_DEPTH = 256,
    parameter int DEF_Q     = 4,
    parameter int DEF_AF    = 4,
    parameter int DEF_AE    = 4,
    localparam int AW       = $clog2(RAM_DEPTH),
    localparam int CW       = $clog2(RAM_DEPTH + 1),
    localparam int QW       = (MAX_Q > 1) ? $clog2(MAX_Q) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_mode_i,
    input  logic              cfg_we_i,
    input  logic [QW-1:0]     cfg_q_i,
    input  logic [CW-1:0]     cfg_size_i,
    input  logic [CW-1:0]     cfg_af_i,
    input  logic [CW-1:0]     cfg_ae_i,
    input  logic              wr_en_i,
    input  logic [QW-1:0]     wr_q_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic [QW-1:0]     rd_q_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o,
    output logic              full_o,
    output logic              empty_o,
    output logic [MAX_Q-1:0]  afull_o,
    output logic [MAX_Q-1:0]  aempty_o
);
    logic [MAX_Q-1:0][AW-1:0] base;
    logic [MAX_Q-1:0][CW-1:0] size, af_thr, ae_thr;
    logic                     load;
    logic [QW-1:0]            load_q;
    logic                     ram_we, ram_re;
    logic [AW-1:0]            ram_waddr, ram_raddr;

    mq_layout #(
        .MAX_Q(MAX_Q), .RAM_DEPTH(RAM_DEPTH), .DEF_Q(DEF_Q),
        .DEF_AF(DEF_AF), .DEF_AE(DEF_AE)
    ) u_layout (
        .clk(clk), .rst_n(rst_n), .prog_mode_i(prog_mode_i),
        .cfg_we_i(cfg_we_i), .cfg_q_i(cfg_q_i), .cfg_size_i(cfg_size_i),
        .cfg_af_i(cfg_af_i), .cfg_ae_i(cfg_ae_i),
        .base_o(base), .size_o(size), .af_o(af_thr), .ae_o(ae_thr),
        .load_o(load), .load_q_o(load_q)
    );

    mq_queues #(.MAX_Q(MAX_Q), .RAM_DEPTH(RAM_DEPTH)) u_queues (
        .clk(clk), .rst_n(rst_n),
        .base_i(base), .size_i(size), .af_i(af_thr), .ae_i(ae_thr),
        .load_i(load), .load_q_i(load_q),
        .wr_en_i(wr_en_i), .wr_q_i(wr_q_i), .rd_en_i(rd_en_i), .rd_q_i(rd_q_i),
        .full_o(full_o), .empty_o(empty_o), .afull_o(afull_o), .aempty_o(aempty_o),
        .ram_we_o(ram_we), .ram_waddr_o(ram_waddr),
        .ram_re_o(ram_re), .ram_raddr_o(ram_raddr)
    );

    mq_ram #(.DATA_W(DATA_W), .RAM_DEPTH(RAM_DEPTH)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .we_i(ram_we), .waddr_i(ram_waddr), .wdata_i(wr_data_i),
        .re_i(ram_re), .raddr_i(ram_raddr),
        .rdata_o(rd_data_o), .rvalid_o(rd_valid_o)
    );
endmodule

// File: tb/mq_fifo_test.sv
`timescale 1ns/1ps
module mq_fifo_test;
    localparam int DATA_W = 16;
    localparam int MAX_Q  = 32;
    localparam int QW     = 5;
    localparam int CW     = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              prog_mode_i = 1'b0;
    logic              cfg_we_i = 1'b0;
    logic [QW-1:0]     cfg_q_i = '0;
    logic [CW-1:0]     cfg_size_i = '0, cfg_af_i = '0, cfg_ae_i = '0;
    logic              wr_en_i = 1'b0;
    logic [QW-1:0]     wr_q_i = '0;
    logic [DATA_W-1:0] wr_data_i = '0;
    logic              rd_en_i = 1'b0;
    logic [QW-1:0]     rd_q_i = '0;
    logic [DATA_W-1:0] rd_data_o;
    logic              rd_valid_o, full_o, empty_o;
    logic [MAX_Q-1:0]  afull_o, aempty_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    mq_fifo uut (.*);

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic do_reset(input logic prog);
        @(negedge clk);
        rst_n = 1'b0; prog_mode_i = prog;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        prog_mode_i = ~prog;
    endtask

    task automatic cfg(input int q, input int sz, input int af, input int ae);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_q_i = QW'(q); cfg_size_i = CW'(sz);
        cfg_af_i = CW'(af); cfg_ae_i = CW'(ae);
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic wr(input int q, input int d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_q_i = QW'(q); wr_data_i = DATA_W'(d);
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input string req, input int q, input int d);
        @(negedge clk);
        rd_en_i = 1'b1; rd_q_i = QW'(q);
        @(negedge clk);
        rd_en_i = 1'b0;
        chk({req, " valid"}, 32'(rd_valid_o), 32'd1);
        chk({req, " data"}, 32'(rd_data_o), 32'(d));
    endtask

    task automatic full_of(input string req, input int q, input logic exp);
        wr_q_i = QW'(q); #1;
        chk(req, 32'(full_o), 32'(exp));
    endtask

    task automatic empty_of(input string req, input int q, input logic exp);
        rd_q_i = QW'(q); #1;
        chk(req, 32'(empty_o), 32'(exp));
    endtask

    task automatic t_reset_default();
        do_reset(1'b0);
        full_of("R1 q0 configured not full", 0, 1'b0);
        full_of("R4 q5 unconfigured full", 5, 1'b1);
        empty_of("R5 q0 empty after reset", 0, 1'b1);
        chk("R9 aempty all at reset", 32'(aempty_o), 32'hFFFF_FFFF);
        chk("R9 afull none at reset", 32'(afull_o), 32'h0);
        chk("R3 rd_valid low at reset", 32'(rd_valid_o), 32'd0);
    endtask

    task automatic t_multi_queue();
        wr(0, 16'h0A01); wr(1, 16'h0B01); wr(0, 16'h0A02); wr(1, 16'h0B02); wr(0, 16'h0A03);
        empty_of("R5 q1 not empty", 1, 1'b0);
        rd("R2 q1 first", 1, 16'h0B01);
        rd("R2 q0 first", 0, 16'h0A01);
        rd("R2 q1 second", 1, 16'h0B02);
        rd("R2 q0 second", 0, 16'h0A02);
        rd("R2 q0 third", 0, 16'h0A03);
        empty_of("R5 q0 drained", 0, 1'b1);
        @(negedge clk);
        chk("R3 rd_valid idle", 32'(rd_valid_o), 32'd0);
    endtask

    task automatic t_full_wrap();
        wr(3, 16'h3333);
        for (int i = 0; i < 64; i++) begin
            wr(2, 16'h2000 + i);
            if (i == 3)  chk("R9 aempty q2 at 4", 32'(aempty_o[2]), 32'd1);
            if (i == 4)  chk("R9 aempty q2 at 5", 32'(aempty_o[2]), 32'd0);
            if (i == 58) chk("R9 afull q2 at 59", 32'(afull_o[2]), 32'd0);
            if (i == 59) chk("R9 afull q2 at 60", 32'(afull_o[2]), 32'd1);
        end
        full_of("R4 q2 full at 64", 2, 1'b1);
        wr(2, 16'hDEAD);
        for (int i = 0; i < 64; i++) rd("R6 q2 drain", 2, 16'h2000 + i);
        empty_of("R6 extra write dropped", 2, 1'b1);
        @(negedge clk);
        rd_en_i = 1'b1; rd_q_i = 2;
        @(negedge clk);
        rd_en_i = 1'b0;
        chk("R7 read of empty no valid", 32'(rd_valid_o), 32'd0);
        empty_of("R7 still empty", 2, 1'b1);
        for (int i = 0; i < 10; i++) wr(2, 16'h2100 + i);
        for (int i = 0; i < 10; i++) rd("R11 wrapped data", 2, 16'h2100 + i);
        rd("R11 neighbour intact", 3, 16'h3333);
    endtask

    task automatic t_same_queue();
        wr(3, 16'h00A0);
        @(negedge clk);
        wr_en_i = 1'b1; wr_q_i = 3; wr_data_i = 16'h00B0;
        rd_en_i = 1'b1; rd_q_i = 3;
        @(negedge clk);
        wr_en_i = 1'b0; rd_en_i = 1'b0;
        chk("R8 concurrent read data", 32'(rd_data_o), 32'h00A0);
        empty_of("R8 count kept at one", 3, 1'b0);
        rd("R8 concurrent write data", 3, 16'h00B0);
        empty_of("R8 empty after", 3, 1'b1);
        @(negedge clk);
        wr_en_i = 1'b1; wr_q_i = 3; wr_data_i = 16'h00C0;
        rd_en_i = 1'b1; rd_q_i = 3;
        @(negedge clk);
        wr_en_i = 1'b0; rd_en_i = 1'b0;
        chk("R8 read of empty ignored", 32'(rd_valid_o), 32'd0);
        rd("R8 write kept", 3, 16'h00C0);
        cfg(5, 8, 1, 1);
        full_of("R10 cfg ignored in default mode", 5, 1'b1);
    endtask

    task automatic t_prog_mode();
        do_reset(1'b1);
        full_of("R1 prog mode q0 unconfigured", 0, 1'b1);
        cfg(1, 4, 1, 1);
        cfg(0, 8, 2, 2);
        cfg(1, 8, 0, 0);
        cfg(2, 250, 0, 0);
        full_of("R10 oversize rejected", 2, 1'b1);
        full_of("R10 q0 accepted", 0, 1'b0);
        wr(1, 16'h1001); wr(1, 16'h1002);
        chk("R9 aempty q1 at 2", 32'(aempty_o[1]), 32'd0);
        chk("R9 afull q1 at 2", 32'(afull_o[1]), 32'd0);
        wr(1, 16'h1003);
        chk("R9 afull q1 at 3", 32'(afull_o[1]), 32'd1);
        wr(1, 16'h1004);
        full_of("R10 q1 kept size 4", 1, 1'b1);
        wr(1, 16'h1005);
        for (int i = 0; i < 8; i++) wr(0, 16'h0E00 + i);
        full_of("R4 q0 full at 8", 0, 1'b1);
        for (int i = 1; i <= 4; i++) rd("R10 q1 region", 1, 16'h1000 + i);
        empty_of("R6 q1 overflow dropped", 1, 1'b1);
        for (int i = 0; i < 8; i++) rd("R10 q0 region", 0, 16'h0E00 + i);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_default();
        t_multi_queue();
        t_full_wrap();
        t_same_queue();
        t_prog_mode();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule